// File: doc/BRIEF.md
# Gray-Scale Step Sequencer with Black-Level Control

This block walks a one-hot ring of gray-scale steps across each active video line. Every pulse of the pixel-rate step enable moves the ring on by one position. The one-hot vector tells the downstream gray-scale generator which step to drive. The ring is not trusted to land back at its start when the line ends. It is therefore cleared whenever the line is not active, so every line starts again at step 1.

A black-level bistable is set by the same line-end clear and cleared by step 1. It holds the digital black flag from the blanking interval through the start of the next line, until the first step appears. A mode input sets the analog black window. In the default window the analog black enable covers the blanking interval. In the alternate window it covers only the time step 1 is shown.

Top module: `gss_top`

## Requirements
- R1: A synchronous active-high reset clears the ring and sets the black bistable. After the reset edge, `step_oh` is all zero and `black_dig` is high.
- R2: The line is active only while `hgate` is 1 and `vblank` is 0. While it is not active, `step_oh` reads all zero with no delay, and the ring is cleared at the next clock edge. This clear wins over a simultaneous `step_en`.
- R3: In an active line, the first clock edge with `step_en` high moves the ring from empty to step 1, shown as `step_oh` bit 0.
- R4: Each later edge with `step_en` high moves the single set bit from bit k to bit k+1. An edge with `step_en` low leaves `step_oh` unchanged.
- R5: An advance from bit STEPS-1 wraps to bit 0 while the line stays active.
- R6: `step_oh` never has more than one bit set.
- R7: `black_dig` is high whenever the line is not active.
- R8: At the start of an active line, `black_dig` stays high until step 1 appears. It goes low while step 1 is shown and stays low for the rest of the line, including after a wrap.
- R9: With `ana_mode` = 0, `black_ana` equals the inverse of line active.
- R10: With `ana_mode` = 1, `black_ana` is high exactly while `step_oh` bit 0 is high.
- R11: A line cut short partway through the ring starts the next line at step 1, and the black flag is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the ring on this edge |
| hgate | input | 1 | High during the active part of a line |
| vblank | input | 1 | High during vertical blanking |
| ana_mode | input | 1 | 0: analog black over blanking; 1: analog black on step 1 only |
| step_oh | output | STEPS | One-hot selected gray step, bit 0 is step 1 |
| black_dig | output | 1 | Digital black-level flag |
| black_ana | output | 1 | Analog black-level enable |

## Verification
The bench raises `step_en` together with a falling gate. A design that let the advance win over the clear would carry a stale step into the next line. It walks the ring past step STEPS so that a missing wrap shows up as an empty vector or as a bit shifted off the top. It cuts a line off halfway through and checks that the next line starts at step 1 with black raised again, not at the stale position. In both analog modes it checks that black follows blanking in mode 0 and step 1 alone in mode 1, and that `vblank` alone suppresses stepping even with the gate high.

// File: rtl/gss_pkg.sv
package gss_pkg;
   typedef enum logic {
      ANA_BLANKING = 1'b0,
      ANA_STEP1    = 1'b1
   } ana_mode_e;
endpackage

// File: rtl/gss_ring.sv
module gss_ring #(
   parameter int STEPS = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             active,
   input  logic             adv,
   output logic [STEPS-1:0] ring_q
);
   initial begin
      if (STEPS < 2) $error("gss_ring: STEPS must be at least 2");
   end

   logic empty;
   assign empty = ~|ring_q;

   for (genvar gi = 0; gi < STEPS; gi++) begin : g_stage
      logic feed;
      if (gi == 0) begin : g_head
         assign feed = empty | ring_q[STEPS-1];
      end else begin : g_body
         assign feed = ring_q[gi-1];
      end
      always_ff @(posedge clk) begin
         if (rst || !active) ring_q[gi] <= 1'b0;
         else if (adv)       ring_q[gi] <= feed;
      end
   end

   // R6
   ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ring_q));
   // R2
   ring_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !active |=> (ring_q == '0));
   // R5
   ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (active && adv && ring_q[STEPS-1]) |=> ring_q[0]);
   // R4
   ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (active && !adv) |=> $stable(ring_q));
endmodule

// File: rtl/gss_black.sv
module gss_black
   import gss_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic step1,
   input  logic ana_mode,
   output logic black_dig,
   output logic black_ana
);
   logic black_q;

   always_ff @(posedge clk) begin
      if (rst || !active) black_q <= 1'b1;
      else if (step1)     black_q <= 1'b0;
   end

   assign black_dig = !active || (black_q && !step1);
   assign black_ana = (ana_mode_e'(ana_mode) == ANA_STEP1) ? step1 : !active;

   // R8
   black_release_chk: assert property (@(posedge clk) disable iff (rst)
      (active && step1) |=> !black_q);
   // R7
   black_blank_chk: assert property (@(posedge clk) disable iff (rst)
      !active |-> black_dig);
endmodule

// File: rtl/gss_top.sv
module gss_top #(
   parameter int STEPS = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_en,
   input  logic             hgate,
   input  logic             vblank,
   input  logic             ana_mode,
   output logic [STEPS-1:0] step_oh,
   output logic             black_dig,
   output logic             black_ana
);
   logic             line_active;
   logic [STEPS-1:0] ring_q;

   assign line_active = hgate && !vblank;
   assign step_oh     = ring_q & {STEPS{line_active}};

   gss_ring #(.STEPS(STEPS)) u_ring (
      .clk    (clk),
      .rst    (rst),
      .active (line_active),
      .adv    (step_en),
      .ring_q (ring_q)
   );

   gss_black u_black (
      .clk       (clk),
      .rst       (rst),
      .active    (line_active),
      .step1     (step_oh[0]),
      .ana_mode  (ana_mode),
      .black_dig (black_dig),
      .black_ana (black_ana)
   );

   // R6
   top_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(step_oh));
   // R10
   top_ana_step_chk: assert property (@(posedge clk) disable iff (rst)
      ana_mode |-> (black_ana == step_oh[0]));
endmodule

// File: tb/gss_top_bench.sv
module gss_top_bench;
   localparam int STEPS = 8;

   logic             clk = 1'b0;
   logic             rst, step_en, hgate, vblank, ana_mode;
   logic [STEPS-1:0] step_oh;
   logic             black_dig, black_ana;
   int               n_cmp = 0;
   int               n_bad = 0;
   bit               done = 1'b0;

   always #2 clk = ~clk;

   gss_top #(.STEPS(STEPS)) u_gss_top (
      .clk(clk), .rst(rst), .step_en(step_en), .hgate(hgate),
      .vblank(vblank), .ana_mode(ana_mode), .step_oh(step_oh),
      .black_dig(black_dig), .black_ana(black_ana)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] oh(int k);
      return (k == 0) ? 32'd0 : (32'd1 << (k - 1));
   endfunction

   task automatic t_reset();
      rst = 1; step_en = 0; hgate = 0; vblank = 0; ana_mode = 0;
      tick(); tick();
      rst = 0; #1;
      chk("R1 steps after reset", step_oh, 0);
      chk("R1 black_dig after reset", black_dig, 1);
      chk("R9 black_ana in blanking", black_ana, 1);
   endtask

   task automatic t_first_and_walk();
      hgate = 1; #1;
      chk("R9 black_ana active line", black_ana, 0);
      tick();
      chk("R8 black before first step", black_dig, 1);
      chk("R3 empty before first step", step_oh, 0);
      step_en = 1; tick();
      chk("R3 first step", step_oh, oh(1));
      chk("R8 black released at step1", black_dig, 0);
      for (int k = 2; k <= STEPS; k++) begin
         tick();
         chk("R4 advance", step_oh, oh(k));
      end
      tick();
      chk("R5 wrap to step1", step_oh, oh(1));
      chk("R8 black stays low after wrap", black_dig, 0);
      step_en = 0; tick(); tick();
      chk("R4 hold without step_en", step_oh, oh(1));
      step_en = 1; tick();
      chk("R4 advance after hold", step_oh, oh(2));
   endtask

   task automatic t_clear_priority();
      hgate = 0; step_en = 1; #1;
      chk("R2 immediate mask", step_oh, 0);
      chk("R7 black in hblank", black_dig, 1);
      tick();
      hgate = 1; step_en = 0; #1;
      chk("R2 cleared over advance", step_oh, 0);
      chk("R8 black at line start", black_dig, 1);
   endtask

   task automatic t_midcut();
      step_en = 1; tick(); tick(); tick();
      chk("R11 mid-line position", step_oh, oh(3));
      hgate = 0; step_en = 0; tick();
      hgate = 1; #1;
      chk("R11 black again", black_dig, 1);
      step_en = 1; tick();
      chk("R11 restart at step1", step_oh, oh(1));
      step_en = 0; hgate = 0; tick();
   endtask

   task automatic t_vblank();
      hgate = 1; vblank = 1; step_en = 1; tick(); tick();
      chk("R2 no steps in vblank", step_oh, 0);
      chk("R7 black in vblank", black_dig, 1);
      chk("R9 black_ana in vblank", black_ana, 1);
      vblank = 0; step_en = 0; hgate = 0; tick();
   endtask

   task automatic t_mode1();
      ana_mode = 1; #1;
      chk("R10 ana low in blanking", black_ana, 0);
      hgate = 1; tick();
      chk("R10 ana low before step1", black_ana, 0);
      step_en = 1; tick();
      chk("R10 ana high on step1", black_ana, 1);
      tick();
      chk("R10 ana low on step2", black_ana, 0);
      chk("R6 single bit", $countones(step_oh), 1);
      step_en = 0; hgate = 0; tick();
      ana_mode = 0;
   endtask

   initial begin
      t_reset();
      t_first_and_walk();
      t_clear_priority();
      t_midcut();
      t_vblank();
      t_mode1();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule